// File: doc/BRIEF.md
# Receive Output Status Controller

This block drives the parallel receive side of a 16-bit serial transceiver. It takes already decoded receive bytes, one K-code flag per byte, the loss-of-signal status from the analog detector, the pass status of the PRBS checker and the recovered clock. From these it produces the registered 16-bit data bus, one flag per byte, a recovered clock output, and active-high output-enable bits that stand in for tri-state pads.

The flag pins carry more than one meaning. The low-byte flag normally marks a K code on bits 7:0, but it reports PRBS pass status while PRBS checking is on. The high-byte flag normally marks a K code on bits 15:8, but it reports loss of signal (active low) while the transceiver is powered down. A fixed priority resolves which meaning applies. From highest to lowest the levels are: power-on reset, power-down, lock-to-reference, loss-of-signal forcing, PRBS override and normal data. Output enables follow the mode inputs combinationally. Output values are registered on the recovered clock.

Top module: `rxos_ctrl`

## Requirements
- R1: While `por` is high, `oe_data` and both `oe_k` bits are 0, `oe_clk` is 1, `rx_clk_out` is low, and `rx_data` and `rx_k` are 0.
- R2: With `por` low and `enable` low (power-down), `oe_k[1]` is 1, and `oe_data`, `oe_k[0]` and `oe_clk` are 0. After each rising clock edge, `rx_k[1]` equals the inverse of `los` as sampled at that edge, so a low level means signal lost.
- R3: With `por` low, `enable` high and `lock_ref_n` low, every output enable (`oe_data`, `oe_k[1:0]`, `oe_clk`) is 0.
- R4: In operating mode (`por` low, `enable` high, `lock_ref_n` high, `los` low), all output enables are 1. After each rising edge, `rx_data` equals `dec_data` and `rx_k[1]` equals `dec_k[1]` as sampled at that edge. The flags map by byte: bit 0 goes with data bits 7:0 and bit 1 with data bits 15:8.
- R5: In operating mode with `los` high, after the edge `rx_data` is all ones and both `rx_k` bits are 1, whatever `prbs_en` is set to.
- R6: In operating mode with `los` low, `rx_k[0]` after the edge equals `prbs_pass` when `prbs_en` is 1 and `dec_k[0]` when `prbs_en` is 0.
- R7: The priority is strict. Reset overrides power-down, and power-down overrides lock-to-reference, so `enable` low together with `lock_ref_n` low gives the power-down behaviour of R2.
- R8: Output enables change in the same cycle as the mode inputs, with no clock edge in between.
- R9: When `por` is low, `rx_clk_out` follows the recovered clock `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock (serial bit rate / 20) |
| por | input | 1 | Power-on reset active, high; also clears output registers asynchronously |
| enable | input | 1 | Device enable; low selects power-down |
| lock_ref_n | input | 1 | Low selects lock-to-reference (transmit-only) |
| prbs_en | input | 1 | PRBS test enable |
| los | input | 1 | Loss of signal from the detector, high when lost |
| prbs_pass | input | 1 | PRBS checker pass status |
| dec_data | input | 16 | Decoded receive data |
| dec_k | input | 2 | Per-byte K-code flags from the decoder |
| rx_data | output | 16 | Receive data bus |
| rx_k | output | 2 | Per-byte K / status flags |
| rx_clk_out | output | 1 | Recovered clock output |
| oe_data | output | 1 | Output enable for the data bus |
| oe_k | output | 2 | Output enable per flag pin |
| oe_clk | output | 1 | Output enable for the clock pin |

## Verification
The bench sweeps every combination of reset, enable, lock-to-reference, loss of signal, PRBS enable and PRBS pass against all four K-flag pairs and varied data words. It compares each output against a priority model written in the bench.

The corner cases are the overlaps between modes:
- Loss of signal during PRBS testing. A design with the order of these two swapped would show the PRBS result instead of a forced high.
- Power-down while lock-to-reference is also low. A design that ranks lock-to-reference higher would tri-state the loss-of-signal flag.
- The polarity of the loss-of-signal indication. A design that gets it wrong would report a lost signal as high.

The enables are sampled before any clock edge, which catches a design that registers them.

// File: rtl/rxos_pkg.sv
package rxos_pkg;
    parameter int unsigned RXOS_LANES  = 2;
    parameter int unsigned RXOS_BYTE_W = 8;
    localparam int unsigned RXOS_DATA_W = RXOS_LANES * RXOS_BYTE_W;

    typedef enum logic [2:0] {
        RXOS_RESET,
        RXOS_PWRDN,
        RXOS_REFLOCK,
        RXOS_LOSFORCE,
        RXOS_PRBS,
        RXOS_DATA
    } rxos_mode_e;

    typedef struct packed {
        logic [RXOS_DATA_W-1:0] data;
        logic [RXOS_LANES-1:0]  kflag;
    } rxos_out_s;

    typedef struct packed {
        logic                  data;
        logic [RXOS_LANES-1:0] kflag;
        logic                  clk;
    } rxos_oe_s;
endpackage

// File: rtl/rxos_mode_dec.sv
module rxos_mode_dec
    import rxos_pkg::*;
(
    input  logic       por,
    input  logic       enable,
    input  logic       lock_ref_n,
    input  logic       los,
    input  logic       prbs_en,
    output rxos_mode_e mode,
    output rxos_oe_s   oe
);
    // Priority resolution, highest first
    always_comb begin
        if (por)              mode = RXOS_RESET;
        else if (!enable)     mode = RXOS_PWRDN;
        else if (!lock_ref_n) mode = RXOS_REFLOCK;
        else if (los)         mode = RXOS_LOSFORCE;
        else if (prbs_en)     mode = RXOS_PRBS;
        else                  mode = RXOS_DATA;
    end

    // Pad enables follow the mode without a register
    always_comb begin
        oe = '0;
        case (mode)
            RXOS_RESET:   oe.clk = 1'b1;
            RXOS_PWRDN:   oe.kflag[RXOS_LANES-1] = 1'b1;
            RXOS_REFLOCK: oe = '0;
            default: begin
                oe.data  = 1'b1;
                oe.kflag = '1;
                oe.clk   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/rxos_out_stage.sv
module rxos_out_stage
    import rxos_pkg::*;
(
    input  logic                   clk,
    input  logic                   por,
    input  rxos_mode_e             mode,
    input  logic [RXOS_DATA_W-1:0] dec_data,
    input  logic [RXOS_LANES-1:0]  dec_k,
    input  logic                   los,
    input  logic                   prbs_pass,
    output rxos_out_s              out_q
);
    rxos_out_s             out_d;
    logic [RXOS_LANES-1:0] lane_k;
    logic                  prbs_sel;

    assign prbs_sel = (mode == RXOS_PRBS);

    // Lane 0 flag may carry the PRBS result; upper lanes carry decoder flags
    for (genvar g = 0; g < RXOS_LANES; g++) begin : g_lane
        if (g == 0) begin : g_prbs
            assign lane_k[g] = prbs_sel ? prbs_pass : dec_k[g];
        end else begin : g_plain
            assign lane_k[g] = dec_k[g];
        end
    end

    always_comb begin
        out_d = out_q;
        case (mode)
            RXOS_RESET:    out_d = '0;
            RXOS_PWRDN:    out_d.kflag[RXOS_LANES-1] = ~los;
            RXOS_REFLOCK:  out_d = out_q;
            RXOS_LOSFORCE: out_d = '1;
            default: begin
                out_d.data  = dec_data;
                out_d.kflag = lane_k;
            end
        endcase
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) out_q <= '0;
        else     out_q <= out_d;
    end
endmodule

// File: rtl/rxos_ctrl.sv
module rxos_ctrl
    import rxos_pkg::*;
(
    input  logic                   clk,
    input  logic                   por,
    input  logic                   enable,
    input  logic                   lock_ref_n,
    input  logic                   prbs_en,
    input  logic                   los,
    input  logic                   prbs_pass,
    input  logic [RXOS_DATA_W-1:0] dec_data,
    input  logic [RXOS_LANES-1:0]  dec_k,
    output logic [RXOS_DATA_W-1:0] rx_data,
    output logic [RXOS_LANES-1:0]  rx_k,
    output logic                   rx_clk_out,
    output logic                   oe_data,
    output logic [RXOS_LANES-1:0]  oe_k,
    output logic                   oe_clk
);
    rxos_mode_e mode;
    rxos_oe_s   oe;
    rxos_out_s  out_q;

    rxos_mode_dec u_mode (
        .por        (por),
        .enable     (enable),
        .lock_ref_n (lock_ref_n),
        .los        (los),
        .prbs_en    (prbs_en),
        .mode       (mode),
        .oe         (oe)
    );

    rxos_out_stage u_out (
        .clk       (clk),
        .por       (por),
        .mode      (mode),
        .dec_data  (dec_data),
        .dec_k     (dec_k),
        .los       (los),
        .prbs_pass (prbs_pass),
        .out_q     (out_q)
    );

    assign rx_data    = out_q.data;
    assign rx_k       = out_q.kflag;
    assign oe_data    = oe.data;
    assign oe_k       = oe.kflag;
    assign oe_clk     = oe.clk;
    assign rx_clk_out = clk & ~por;

    logic operating;
    assign operating = enable && lock_ref_n;

    p_pwrdn_oe_r2: assert property (@(posedge clk) disable iff (por)
        !enable |-> (oe_k[RXOS_LANES-1] && !oe_data && !oe_k[0] && !oe_clk));

    p_pwrdn_los_r2: assert property (@(posedge clk) disable iff (por)
        !enable |=> (rx_k[RXOS_LANES-1] == !$past(los)));

    p_reflock_tri_r3: assert property (@(posedge clk) disable iff (por)
        (enable && !lock_ref_n) |-> (!oe_data && oe_k == '0 && !oe_clk));

    p_normal_data_r4: assert property (@(posedge clk) disable iff (por)
        (operating && !los) |=> (rx_data == $past(dec_data)));

    p_los_force_r5: assert property (@(posedge clk) disable iff (por)
        (operating && los) |=> (rx_data == '1 && rx_k == '1));

    p_prbs_flag_r6: assert property (@(posedge clk) disable iff (por)
        (operating && !los && prbs_en) |=> (rx_k[0] == $past(prbs_pass)));
endmodule

// File: tb/rxos_ctrl_test.sv
module rxos_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por, enable, lock_ref_n, prbs_en, los, prbs_pass;
    logic [15:0] dec_data;
    logic [1:0]  dec_k;
    logic [15:0] rx_data;
    logic [1:0]  rx_k, oe_k;
    logic        rx_clk_out, oe_data, oe_clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxos_ctrl uut (
        .clk(clk), .por(por), .enable(enable), .lock_ref_n(lock_ref_n),
        .prbs_en(prbs_en), .los(los), .prbs_pass(prbs_pass),
        .dec_data(dec_data), .dec_k(dec_k), .rx_data(rx_data), .rx_k(rx_k),
        .rx_clk_out(rx_clk_out), .oe_data(oe_data), .oe_k(oe_k), .oe_clk(oe_clk)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        por = 1'b1; enable = 1'b1; lock_ref_n = 1'b1; prbs_en = 1'b0;
        los = 1'b0; prbs_pass = 1'b0; dec_data = '0; dec_k = '0;
        @(negedge clk);
        check(rx_data == 16'h0 && rx_k == 2'b00, "R1 reset state", {14'h0, rx_k, rx_data}, 32'h0);
        for (int p = 1; p >= 0; p--) begin
            for (int m = 0; m < 32; m++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [3:0]  exp_oe;
                    logic [15:0] dpat;
                    bit          e, ln, ls, pe, pp;
                    e  = m[0]; ln = m[1]; ls = m[2]; pe = m[3]; pp = m[4];
                    dpat = 16'((m * 4 + k) * 16'h1357) ^ 16'hA5C3 ^ 16'(p);
                    por = p[0]; enable = e; lock_ref_n = ln; los = ls;
                    prbs_en = pe; prbs_pass = pp; dec_data = dpat; dec_k = 2'(k);
                    #1;
                    // expected enables {data, k1, k0, clk}
                    if (p != 0)  exp_oe = 4'b0001;
                    else if (!e) exp_oe = 4'b0100;
                    else if (!ln) exp_oe = 4'b0000;
                    else exp_oe = 4'b1111;
                    // R8: enables settle before any clock edge
                    check({oe_data, oe_k, oe_clk} == exp_oe,
                          (p != 0) ? "R1 R8 enables" : (!e ? (!ln ? "R7 R2 R8 enables" : "R2 R8 enables")
                          : (!ln ? "R3 R8 enables" : "R4 R8 enables")),
                          {28'h0, oe_data, oe_k, oe_clk}, {28'h0, exp_oe});
                    @(posedge clk);
                    #(CLK_PERIOD/4);
                    check(rx_clk_out == (p == 0), (p != 0) ? "R1 clock held low" : "R9 clock follows",
                          {31'h0, rx_clk_out}, {31'h0, (p == 0)});
                    @(negedge clk);
                    if (p != 0) begin
                        check(rx_data == 16'h0 && rx_k == 2'b00, "R1 registers cleared",
                              {14'h0, rx_k, rx_data}, 32'h0);
                    end else if (!e) begin
                        check(rx_k[1] == !ls, "R2 los status active low",
                              {31'h0, rx_k[1]}, {31'h0, !ls});
                    end else if (ln) begin
                        if (ls) begin
                            check(rx_data == 16'hFFFF && rx_k == 2'b11, "R5 los forces high",
                                  {14'h0, rx_k, rx_data}, 32'h3FFFF);
                        end else begin
                            logic [1:0] ek;
                            ek = {k[1], pe ? pp : k[0]};
                            check(rx_data == dpat, "R4 data passes", {16'h0, rx_data}, {16'h0, dpat});
                            check(rx_k == ek, pe ? "R6 prbs flag" : "R4 K flags",
                                  {30'h0, rx_k}, {30'h0, ek});
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule